// File: doc/BRIEF.md
# Power-Line FSK Packet Framer

This block turns a loaded payload into the serial bit stream of one power-line FSK transmit packet. A host interface first writes the body bytes into a small internal buffer, one byte per write. A start request then launches the packet. The framer presents one bit at a time to the carrier generator and moves to the next bit on each bit-time strobe. The bits come in a fixed order: a 16-bit bit-sync preamble (0xAAAA), a 16-bit word-sync pattern (0x54C7), the 38-byte body with its CRC bytes already in place, and a 24-bit pause/end trailer. That makes 360 bits, or 300 ms at 1200 bit/s.

An optional differential precoder can be enabled for each packet. With it, a differential receiver gets the data back directly. The busy output is meant to drive a transmit status lamp. A one-cycle done pulse marks the end of the trailer.

Top module: `fsk_packet_framer`

## Requirements
- R1: After reset, busy, done and tx_bit are all 0.
- R2: A start request while idle raises busy on the next clock edge. The packet opens with the 16-bit bit-sync value 0xAAAA sent MSB first, so the first bit is 1 and the bits alternate.
- R3: Packet bits 16 to 31 are the word-sync value 0x54C7, sent MSB first.
- R4: Packet bits 32 to 335 are body bytes 0 to 37 in index order, each sent MSB first. A write to byte address a stores the byte in 16-bit buffer word a>>1: even addresses fill bits 7..0 and odd addresses fill bits 15..8. A write to an address of 38 or more changes nothing.
- R5: The last 24 bits are the trailer value (default all zero), so a packet is exactly 360 bits long.
- R6: Each bit stays on tx_bit until the next bit-time strobe. A strobe while idle has no effect.
- R7: done is a single-cycle pulse. It appears in the first cycle after the strobe that ends bit 359, and busy is low in that same cycle.
- R8: A start request while busy is ignored. The running packet keeps its bit order and its length.
- R9: If diff_en is 1 when a packet starts, every transmitted bit is the raw bit XOR the previously transmitted bit, and the precoder state is 0 at packet start. If diff_en is 0, the raw bits go out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Payload byte write strobe |
| wr_addr | input | 6 | Payload byte address (0 to 37 valid) |
| wr_data | input | 8 | Payload byte value |
| diff_en | input | 1 | Enable the differential precoder; sampled when a start is accepted |
| start | input | 1 | Packet start request |
| bit_stb | input | 1 | Bit-time strobe from the carrier timing |
| tx_bit | output | 1 | Current transmit bit to the carrier generator |
| busy | output | 1 | High from the first preamble bit through the last trailer bit |
| done | output | 1 | One-cycle pulse after the final trailer bit |

## Verification
Some properties are checked on every cycle:
- The field position stays frozen while busy with no strobe. This covers both holding each bit and ignoring a start request.
- The first bit after busy rises equals the preamble MSB.
- done is a lone pulse, arrives with busy low, and comes exactly 360 strobes after launch.
- A precoded bit XOR its raw bit equals the previous transmitted bit.
- An out-of-range write leaves the buffer read unchanged.

Other behaviour only the bench scenarios can show:
- The exact content of each field in order.
- Byte lane placement in the buffer.
- The full precoded sequence.
- That idle strobes and a mid-packet start leave no trace at the outputs.

// File: rtl/fsk_framer_pkg.sv
package fsk_framer_pkg;
   typedef enum logic [2:0] {
      FLD_IDLE  = 3'd0,
      FLD_BSYNC = 3'd1,
      FLD_WSYNC = 3'd2,
      FLD_BODY  = 3'd3,
      FLD_TRAIL = 3'd4
   } fld_e;
endpackage

// File: rtl/fsk_payload_buf.sv
module fsk_payload_buf #(
   parameter int BODY_BYTES = 38,
   parameter int AW         = $clog2(BODY_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic [AW-1:0] rd_idx,
   output logic [7:0]    rd_byte
);
   localparam int WORDS = (BODY_BYTES + 1) / 2;

   logic [15:0] mem [WORDS];
   logic        in_range;

   assign in_range = (32'(wr_addr) < BODY_BYTES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) mem[w] <= '0;
      end else if (wr_en && in_range) begin
         if (wr_addr[0]) mem[wr_addr[AW-1:1]][15:8] <= wr_data;
         else            mem[wr_addr[AW-1:1]][7:0]  <= wr_data;
      end
   end

   assign rd_byte = rd_idx[0] ? mem[rd_idx[AW-1:1]][15:8] : mem[rd_idx[AW-1:1]][7:0];

   // R4: writes past the body never disturb what the reader sees
   a_r4_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !in_range) |=> (!$stable(rd_idx) || $stable(rd_byte)));
endmodule

// File: rtl/fsk_field_seq.sv
module fsk_field_seq
   import fsk_framer_pkg::*;
#(
   parameter int SYNC_W     = 16,
   parameter int BODY_BYTES = 38,
   parameter int TRAIL_W    = 24,
   parameter int CW         = 5,
   parameter int BW         = $clog2(BODY_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic          adv,
   output fld_e          fld,
   output logic [CW-1:0] cnt,
   output logic [BW-1:0] byte_idx,
   output logic          last
);
   fld_e          fld_q;
   logic [CW-1:0] cnt_q;
   logic [BW-1:0] byte_q;
   logic          moving;

   assign moving = adv && (fld_q != FLD_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fld_q  <= FLD_IDLE;
         cnt_q  <= '0;
         byte_q <= '0;
      end else if (launch && fld_q == FLD_IDLE) begin
         fld_q  <= FLD_BSYNC;
         cnt_q  <= CW'(SYNC_W - 1);
         byte_q <= '0;
      end else if (moving) begin
         if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end else begin
            unique case (fld_q)
               FLD_BSYNC: begin
                  fld_q <= FLD_WSYNC;
                  cnt_q <= CW'(SYNC_W - 1);
               end
               FLD_WSYNC: begin
                  fld_q  <= FLD_BODY;
                  cnt_q  <= CW'(7);
                  byte_q <= '0;
               end
               FLD_BODY: begin
                  if (byte_q == BW'(BODY_BYTES - 1)) begin
                     fld_q <= FLD_TRAIL;
                     cnt_q <= CW'(TRAIL_W - 1);
                  end else begin
                     byte_q <= byte_q + 1'b1;
                     cnt_q  <= CW'(7);
                  end
               end
               default: fld_q <= FLD_IDLE;
            endcase
         end
      end
   end

   assign fld      = fld_q;
   assign cnt      = cnt_q;
   assign byte_idx = byte_q;
   assign last     = moving && (fld_q == FLD_TRAIL) && (cnt_q == '0);

   // R6, R8: with no strobe the position is frozen, whatever start does
   a_r6_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (fld_q != FLD_IDLE && !adv) |=> ($stable(fld_q) && $stable(cnt_q) && $stable(byte_q)));
endmodule

// File: rtl/fsk_precoder.sv
module fsk_precoder #(
   parameter bit HAS_PRECODER = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic adv,
   input  logic en,
   input  logic raw,
   output logic coded
);
   generate
      if (HAS_PRECODER) begin : g_diff
         logic prev_q;
         logic en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               en_q   <= 1'b0;
            end else if (clear) begin
               prev_q <= 1'b0;
               en_q   <= en;
            end else if (adv) begin
               prev_q <= coded;
            end
         end
         assign coded = raw ^ (en_q & prev_q);

         // R9: a precoded bit XOR its raw bit is the bit sent before it
         a_r9_diff_relation: assert property (@(posedge clk) disable iff (!rst_n)
            (adv && en_q && !clear) |=> ((coded ^ raw) == $past(coded)));
      end else begin : g_plain
         assign coded = raw;
      end
   endgenerate
endmodule

// File: rtl/fsk_packet_framer.sv
module fsk_packet_framer
   import fsk_framer_pkg::*;
#(
   parameter int                  SYNC_W       = 16,
   parameter logic [SYNC_W-1:0]   BITSYNC_PAT  = 16'hAAAA,
   parameter logic [SYNC_W-1:0]   WORDSYNC_PAT = 16'h54C7,
   parameter int                  BODY_BYTES   = 38,
   parameter int                  TRAIL_W      = 24,
   parameter logic [TRAIL_W-1:0]  TRAIL_PAT    = '0,
   parameter bit                  HAS_PRECODER = 1'b1,
   localparam int                 AW           = $clog2(BODY_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic          diff_en,
   input  logic          start,
   input  logic          bit_stb,
   output logic          tx_bit,
   output logic          busy,
   output logic          done
);
   localparam int SCW      = $clog2(SYNC_W);
   localparam int TCW      = $clog2(TRAIL_W);
   localparam int CW       = (TCW > SCW) ? ((TCW > 3) ? TCW : 3) : ((SCW > 3) ? SCW : 3);
   localparam int PKT_BITS = 2 * SYNC_W + 8 * BODY_BYTES + TRAIL_W;
   localparam int PCW      = $clog2(PKT_BITS + 1);

   generate
      if (SYNC_W < 2 || (1 << SCW) != SYNC_W) begin : g_bad_sync
         $error("SYNC_W must be a power of two of at least 2");
      end
      if (BODY_BYTES < 2) begin : g_bad_body
         $error("BODY_BYTES must be at least 2");
      end
      if (TRAIL_W < 2) begin : g_bad_trail
         $error("TRAIL_W must be at least 2");
      end
   endgenerate

   fld_e          fld;
   logic [CW-1:0] cnt;
   logic [AW-1:0] byte_idx;
   logic [7:0]    rd_byte;
   logic          last, launch, adv, raw, coded, done_q;

   assign busy   = (fld != FLD_IDLE);
   assign launch = start && !busy;
   assign adv    = bit_stb && busy;

   fsk_payload_buf #(.BODY_BYTES(BODY_BYTES), .AW(AW)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_idx(byte_idx), .rd_byte(rd_byte));

   fsk_field_seq #(.SYNC_W(SYNC_W), .BODY_BYTES(BODY_BYTES), .TRAIL_W(TRAIL_W),
                   .CW(CW), .BW(AW)) u_seq (
      .clk(clk), .rst_n(rst_n), .launch(launch), .adv(adv),
      .fld(fld), .cnt(cnt), .byte_idx(byte_idx), .last(last));

   always_comb begin
      unique case (fld)
         FLD_BSYNC: raw = BITSYNC_PAT[cnt[SCW-1:0]];
         FLD_WSYNC: raw = WORDSYNC_PAT[cnt[SCW-1:0]];
         FLD_BODY:  raw = rd_byte[cnt[2:0]];
         FLD_TRAIL: raw = TRAIL_PAT[cnt[TCW-1:0]];
         default:   raw = 1'b0;
      endcase
   end

   fsk_precoder #(.HAS_PRECODER(HAS_PRECODER)) u_pre (
      .clk(clk), .rst_n(rst_n), .clear(launch), .adv(adv),
      .en(diff_en), .raw(raw), .coded(coded));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= last;
   end

   assign tx_bit = busy & coded;
   assign done   = done_q;

   // strobe tally used only by the length check below
   logic [PCW-1:0] stb_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stb_seen <= '0;
      else if (launch) stb_seen <= '0;
      else if (adv)    stb_seen <= stb_seen + 1'b1;
   end

   a_r2_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (tx_bit == BITSYNC_PAT[SYNC_W-1]));
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   a_r5_packet_length: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (stb_seen == PCW'(PKT_BITS)));
endmodule

// File: tb/sim_fsk_packet_framer.sv
module sim_fsk_packet_framer;
   localparam int NB   = 38;
   localparam int NBIT = 360;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [5:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       diff_en = 1'b0;
   logic       start = 1'b0;
   logic       bit_stb = 1'b0;
   logic       tx_bit, busy, done;

   always #10 clk = ~clk;

   fsk_packet_framer u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .diff_en(diff_en), .start(start), .bit_stb(bit_stb),
      .tx_bit(tx_bit), .busy(busy), .done(done));

   int   total = 0;
   int   bad = 0;
   bit   cur_pre = 1'b0;
   bit   finished = 1'b0;
   logic [7:0] pay [NB];
   bit   exp_q[$];
   int   idx_q[$];

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
      end
   endtask

   function automatic string field_req(input int k);
      if (cur_pre)  return "R9";
      if (k < 16)   return "R2";
      if (k < 32)   return "R3";
      if (k < 336)  return "R4";
      return "R5";
   endfunction

   function automatic bit raw_bit(input int k);
      logic [15:0] bs = 16'hAAAA;
      logic [15:0] ws = 16'h54C7;
      if (k < 16) return bs[15-k];
      if (k < 32) return ws[15-(k-16)];
      if (k < 336) return pay[(k-32)/8][7-((k-32)%8)];
      return 1'b0;
   endfunction

   // monitor: pops expected bits on strobe cycles, checks holding in between
   always @(negedge clk) begin
      if (rst_n && busy) begin
         if (bit_stb) begin
            if (exp_q.size() == 0) chk(1'b0, "R5", 1, 0);
            else begin
               automatic bit e = exp_q.pop_front();
               automatic int k = idx_q.pop_front();
               chk(tx_bit == e, field_req(k), tx_bit, e);
            end
         end else if (exp_q.size() > 0) begin
            chk(tx_bit == exp_q[0], "R6", tx_bit, exp_q[0]);
         end
      end
   end

   task automatic wr_byte(input int a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
      @(posedge clk); #2;
      wr_en = 1'b0;
   endtask

   task automatic load_payload(input int seed);
      for (int i = 0; i < NB; i++) begin
         pay[i] = 8'((i * seed + 8'h5A) ^ (i << 3));
         wr_byte(i, pay[i]);
      end
   endtask

   // driver: pushes expectations, launches, strobes
   task automatic run_packet(input bit pre, input int gapmode, input int poke_at);
      automatic bit prev = 1'b0;
      for (int k = 0; k < NBIT; k++) begin
         automatic bit b = raw_bit(k) ^ (pre & prev);
         prev = b;
         exp_q.push_back(b);
         idx_q.push_back(k);
      end
      cur_pre = pre;
      diff_en = pre; start = 1'b1;
      @(posedge clk); #2;
      start = 1'b0; diff_en = 1'b0;
      @(negedge clk);
      chk(busy == 1'b1, "R2", busy, 1);
      @(posedge clk); #2;
      for (int i = 0; i < NBIT; i++) begin
         automatic int gap = (gapmode == 0) ? 0 : (i % 3);
         for (int g = 0; g < gap; g++) begin
            @(posedge clk); #2;
         end
         if (i == poke_at) begin
            start = 1'b1;
            @(posedge clk); #2;
            start = 1'b0;
            @(negedge clk);
            chk(busy == 1'b1, "R8", busy, 1);
            @(posedge clk); #2;
         end
         bit_stb = 1'b1;
         @(posedge clk); #2;
         bit_stb = 1'b0;
      end
      @(negedge clk);
      chk(done == 1'b1, "R7", done, 1);
      chk(busy == 1'b0, "R7", busy, 0);
      chk(exp_q.size() == 0, "R5", exp_q.size(), 0);
      @(negedge clk);
      chk(done == 1'b0, "R7", done, 0);
      @(posedge clk); #2;
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL R7 watchdog expired actual=busy%0d expected=done", busy);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R1", busy, 0);
      chk(done == 1'b0, "R1", done, 0);
      chk(tx_bit == 1'b0, "R1", tx_bit, 0);
      @(posedge clk); #2;

      // plain packet, back-to-back strobes
      load_payload(37);
      run_packet(1'b0, 0, -1);

      // strobes while idle do nothing (R6)
      for (int s = 0; s < 3; s++) begin
         bit_stb = 1'b1;
         @(posedge clk); #2;
         bit_stb = 1'b0;
      end
      @(negedge clk);
      chk(busy == 1'b0, "R6", busy, 0);
      chk(tx_bit == 1'b0, "R6", tx_bit, 0);
      chk(done == 1'b0, "R6", done, 0);
      @(posedge clk); #2;

      // precoded packet, gapped strobes, start poked mid-body (R8, R9)
      load_payload(91);
      run_packet(1'b1, 1, 100);

      // odd/even lanes and out-of-range writes (R4)
      load_payload(13);
      wr_byte(38, 8'hFF);
      wr_byte(63, 8'hFF);
      wr_byte(39, 8'hC3);
      pay[5] = 8'h81; wr_byte(5, 8'h81);
      pay[6] = 8'h7E; wr_byte(6, 8'h7E);
      run_packet(1'b0, 1, 340);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule